// File: doc/BRIEF.md
# Packet Bulk Loopback Engine

This block moves whole packets from a receive buffer pool to a transmit buffer pool. Each pool holds a fixed number of packet slots (two by default) of a fixed size (512 bytes by default). A producer arms receive slots, streams bytes into the current slot and then commits it. The committed byte count goes with the slot. A consumer reads committed transmit packets byte by byte, sees each packet's length, and releases the slot when it is done.

The engine waits until the receive pool has at least one committed packet and the transmit pool has at least one free slot. It then copies the packet one byte per clock. The read pointer and the write pointer each advance by themselves. The engine commits the transmit slot with the same byte count and, one cycle later, hands the receive slot back as armed. Empty and full indications on both pools move only on packet events (commit, release, arm) and never on single bytes.

Top module: `lbk_bulk_loopback`

## Requirements
- R1: After reset the receive pool shows empty and full (no slot armed), the transmit pool shows empty and not full, and `busy` is low.
- R2: Receive slots start unarmed. Each `rx_arm` pulse readies one slot, up to the slot count. While no receive slot is armed, byte writes and commits are dropped and `rx_empty` stays high.
- R3: `rx_empty` falls in the cycle after a commit and never because of a byte write. `tx_empty` stays high during a copy until that copy's commit.
- R4: A copy starts only when `rx_empty` is low and `tx_full` is low. While the transmit pool is full, a waiting receive packet stays put and `busy` stays low.
- R5: `tx_pkt_len` equals the byte count committed on the receive side, for any count from 0 to the buffer size (512) inclusive.
- R6: The bytes of a packet come out unchanged and in write order. `tx_rd_data` shows the byte at the read pointer, and each cycle with `tx_rd_en` high advances the pointer by one.
- R7: Packets leave the transmit pool in the order they were committed on the receive side.
- R8: A copy of N bytes keeps `busy` high for exactly N+2 cycles: one byte per cycle, then one commit cycle and one release cycle.
- R9: The transmit commit happens exactly one cycle before the receive slot is released. `tx_empty` falls one cycle before `rx_empty` rises when a single packet is in flight.
- R10: A receive slot returns to the armed state after its packet is copied, so the producer can reuse both slots without arming again.
- R11: A `tx_release` pulse frees the transmit slot being read, and `tx_full` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_arm | input | 1 | Pulse: arm one receive slot |
| rx_wr_en | input | 1 | Write one byte into the receive fill slot |
| rx_wr_data | input | DATA_W | Byte to write |
| rx_commit | input | 1 | Pulse: close the fill slot with the bytes written so far |
| rx_empty | output | 1 | No committed receive packet |
| rx_full | output | 1 | No armed receive slot |
| tx_rd_en | input | 1 | Advance the transmit read pointer |
| tx_release | input | 1 | Pulse: free the transmit slot being read |
| tx_rd_data | output | DATA_W | Byte at the transmit read pointer |
| tx_pkt_len | output | CNT_W | Byte count of the transmit packet being read |
| tx_empty | output | 1 | No committed transmit packet |
| tx_full | output | 1 | No free transmit slot |
| busy | output | 1 | Copy engine not idle |

## Verification
The assertions assume that the producer never raises `rx_wr_en` and `rx_commit` in the same cycle and never writes more bytes than a slot holds. They also assume that `tx_rd_en` and `tx_release` are used only while a transmit packet is present. The bench drives each byte and each pulse on its own falling edge. It waits on `rx_full` before writing, stops each packet at its length, and reads or releases only after it has seen `tx_empty` low. Under these limits, a receive flag change can only come from an accepted commit or release, and every transmit commit carries the count the engine latched.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COPY,
    ST_COMMIT,
    ST_RELEASE
  } copy_st_e;

  // ring index step over n slots
  function automatic int unsigned slot_next(int unsigned idx, int unsigned n);
    return (idx + 32'd1 >= n) ? 32'd0 : idx + 32'd1;
  endfunction

  // occupancy update: two possible increments, one decrement
  function automatic int unsigned occ_next(int unsigned cur, logic inc_a, logic inc_b, logic dec);
    return cur + 32'(inc_a) + 32'(inc_b) - 32'(dec);
  endfunction

  // a slot may be armed while armed + filled stays below the slot count
  function automatic logic has_room(int unsigned armed, int unsigned filled, int unsigned slots);
    return (armed + filled) < slots;
  endfunction

  // true on the cycle that moves the final byte
  function automatic logic last_beat(int unsigned moved, int unsigned total);
    return (moved + 32'd1) == total;
  endfunction

endpackage

// File: rtl/lbk_pkt_pool.sv
module lbk_pkt_pool #(
  parameter int DATA_W     = 8,
  parameter int BUF_BYTES  = 512,
  parameter int SLOTS      = 2,
  parameter int CNT_W      = 11,
  parameter int INIT_ARMED = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              rd_en_i,
  input  logic              release_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  rd_len_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              commit_ok_o,
  output logic              release_ok_o,
  output logic [CNT_W-1:0]  wr_count_o
);
  localparam int PTR_W = $clog2(BUF_BYTES);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int OCC_W = $clog2(SLOTS + 1);
  localparam int DEPTH = 1 << (IDX_W + PTR_W);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  len_q [SLOTS];
  logic [IDX_W-1:0]  wr_idx_q, rd_idx_q;
  logic [CNT_W-1:0]  wr_cnt_q, rd_ptr_q;
  logic [OCC_W-1:0]  armed_q, filled_q;
  logic [CNT_W-1:0]  cur_len;
  logic              wr_ok, rd_ok, arm_ok, commit_ok, release_ok;

  assign cur_len    = len_q[rd_idx_q];
  assign arm_ok     = arm_i && lbk_pkg::has_room(32'(armed_q), 32'(filled_q), SLOTS);
  assign wr_ok      = wr_en_i && (armed_q != '0) && (32'(wr_cnt_q) < BUF_BYTES);
  assign rd_ok      = rd_en_i && (filled_q != '0) && (rd_ptr_q < cur_len);
  assign commit_ok  = commit_i && (armed_q != '0);
  assign release_ok = release_i && (filled_q != '0);

  assign rd_data_o    = mem_q[{rd_idx_q, rd_ptr_q[PTR_W-1:0]}];
  assign rd_len_o     = cur_len;
  assign empty_o      = (filled_q == '0);
  assign full_o       = (armed_q == '0);
  assign commit_ok_o  = commit_ok;
  assign release_ok_o = release_ok;
  assign wr_count_o   = wr_cnt_q;

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[{wr_idx_q, wr_cnt_q[PTR_W-1:0]}] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      wr_cnt_q <= '0;
      rd_ptr_q <= '0;
      armed_q  <= OCC_W'(INIT_ARMED);
      filled_q <= '0;
      for (int s = 0; s < SLOTS; s++) len_q[s] <= '0;
    end else begin
      if (commit_ok) begin
        len_q[wr_idx_q] <= wr_cnt_q;
        wr_idx_q <= IDX_W'(lbk_pkg::slot_next(32'(wr_idx_q), SLOTS));
        wr_cnt_q <= '0;
      end else if (wr_ok) begin
        wr_cnt_q <= wr_cnt_q + 1'b1;
      end
      if (release_ok) begin
        rd_idx_q <= IDX_W'(lbk_pkg::slot_next(32'(rd_idx_q), SLOTS));
        rd_ptr_q <= '0;
      end else if (rd_ok) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
      armed_q  <= OCC_W'(lbk_pkg::occ_next(32'(armed_q), arm_ok, release_ok, commit_ok));
      filled_q <= OCC_W'(lbk_pkg::occ_next(32'(filled_q), commit_ok, 1'b0, release_ok));
    end
  end

endmodule

// File: rtl/lbk_copy_fsm.sv
module lbk_copy_fsm #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_empty_i,
  input  logic             dst_full_i,
  input  logic [CNT_W-1:0] src_len_i,
  output logic             src_rd_o,
  output logic             dst_wr_o,
  output logic             dst_commit_o,
  output logic             src_release_o,
  output logic             start_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] len_o
);
  import lbk_pkg::*;

  copy_st_e         state_q;
  logic [CNT_W-1:0] len_q, cnt_q;

  always_comb begin
    start_o       = (state_q == ST_IDLE) && !src_empty_i && !dst_full_i;
    src_rd_o      = (state_q == ST_COPY);
    dst_wr_o      = (state_q == ST_COPY);
    dst_commit_o  = (state_q == ST_COMMIT);
    src_release_o = (state_q == ST_RELEASE);
    busy_o        = (state_q != ST_IDLE);
    len_o         = len_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_o) begin
            len_q   <= src_len_i;
            cnt_q   <= '0;
            state_q <= (src_len_i == '0) ? ST_COMMIT : ST_COPY;
          end
        end
        ST_COPY: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_beat(32'(cnt_q), 32'(len_q))) state_q <= ST_COMMIT;
        end
        ST_COMMIT:  state_q <= ST_RELEASE;
        ST_RELEASE: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lbk_bulk_loopback.sv
module lbk_bulk_loopback #(
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 512,
  parameter int SLOTS     = 2,
  parameter int CNT_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_arm,
  input  logic              rx_wr_en,
  input  logic [DATA_W-1:0] rx_wr_data,
  input  logic              rx_commit,
  output logic              rx_empty,
  output logic              rx_full,
  input  logic              tx_rd_en,
  input  logic              tx_release,
  output logic [DATA_W-1:0] tx_rd_data,
  output logic [CNT_W-1:0]  tx_pkt_len,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              busy
);
  // named internal events, observed by the bound checker
  logic [DATA_W-1:0] rx_rd_data;
  logic [CNT_W-1:0]  rx_len, copy_len, rx_wr_count, tx_wr_count;
  logic              copy_rd, copy_wr, copy_commit, copy_release, copy_start;
  logic              rx_commit_evt, rx_release_evt, tx_commit_evt, tx_release_evt;

  lbk_pkt_pool #(
    .DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES), .SLOTS(SLOTS), .CNT_W(CNT_W), .INIT_ARMED(0)
  ) rx_pool_i (
    .clk(clk), .rst_n(rst_n),
    .arm_i(rx_arm), .wr_en_i(rx_wr_en), .wr_data_i(rx_wr_data), .commit_i(rx_commit),
    .rd_en_i(copy_rd), .release_i(copy_release),
    .rd_data_o(rx_rd_data), .rd_len_o(rx_len),
    .empty_o(rx_empty), .full_o(rx_full),
    .commit_ok_o(rx_commit_evt), .release_ok_o(rx_release_evt), .wr_count_o(rx_wr_count)
  );

  lbk_copy_fsm #(.CNT_W(CNT_W)) copy_i (
    .clk(clk), .rst_n(rst_n),
    .src_empty_i(rx_empty), .dst_full_i(tx_full), .src_len_i(rx_len),
    .src_rd_o(copy_rd), .dst_wr_o(copy_wr), .dst_commit_o(copy_commit),
    .src_release_o(copy_release), .start_o(copy_start), .busy_o(busy), .len_o(copy_len)
  );

  lbk_pkt_pool #(
    .DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES), .SLOTS(SLOTS), .CNT_W(CNT_W), .INIT_ARMED(SLOTS)
  ) tx_pool_i (
    .clk(clk), .rst_n(rst_n),
    .arm_i(1'b0), .wr_en_i(copy_wr), .wr_data_i(rx_rd_data), .commit_i(copy_commit),
    .rd_en_i(tx_rd_en), .release_i(tx_release),
    .rd_data_o(tx_rd_data), .rd_len_o(tx_pkt_len),
    .empty_o(tx_empty), .full_o(tx_full),
    .commit_ok_o(tx_commit_evt), .release_ok_o(tx_release_evt), .wr_count_o(tx_wr_count)
  );

endmodule

// File: rtl/lbk_loopback_chk.sv
module lbk_loopback_chk #(
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             copy_start,
  input logic             copy_wr,
  input logic             rx_empty,
  input logic             rx_full,
  input logic             tx_full,
  input logic             busy,
  input logic             rx_commit_evt,
  input logic             rx_release_evt,
  input logic             tx_commit_evt,
  input logic             tx_release_evt,
  input logic [CNT_W-1:0] copy_len,
  input logic [CNT_W-1:0] tx_wr_count,
  input logic [CNT_W-1:0] rx_wr_count
);
  localparam int LIMIT = BUF_BYTES + 2;
  logic [CNT_W:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  AST_START_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> (!rx_empty && !tx_full)); // R4
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    copy_wr |-> !tx_full); // R4
  AST_FLAG_PACKET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_commit_evt && !rx_release_evt) |=> $stable(rx_empty)); // R3
  AST_LEN_PRESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_commit_evt |-> (tx_wr_count == copy_len)); // R5
  AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_wr_count) <= BUF_BYTES); // R5
  AST_COMMIT_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_commit_evt |=> rx_release_evt); // R9
  AST_RELEASE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_release_evt |-> $past(tx_commit_evt)); // R9
  AST_COPY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(run_q) < LIMIT)); // R8
  AST_TX_SLOT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_release_evt |=> !tx_full); // R11
  AST_RX_REARMED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_release_evt |=> !rx_full); // R10

endmodule

bind lbk_bulk_loopback lbk_loopback_chk #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .copy_start(copy_start), .copy_wr(copy_wr),
  .rx_empty(rx_empty), .rx_full(rx_full), .tx_full(tx_full), .busy(busy),
  .rx_commit_evt(rx_commit_evt), .rx_release_evt(rx_release_evt),
  .tx_commit_evt(tx_commit_evt), .tx_release_evt(tx_release_evt),
  .copy_len(copy_len), .tx_wr_count(tx_wr_count), .rx_wr_count(rx_wr_count)
);

// File: tb/lbk_bulk_loopback_tb_top.sv
module lbk_bulk_loopback_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_arm = 1'b0, rx_wr_en = 1'b0, rx_commit = 1'b0;
  logic [7:0] rx_wr_data = '0;
  logic tx_rd_en = 1'b0, tx_release = 1'b0;
  logic rx_empty, rx_full, tx_empty, tx_full, busy;
  logic [7:0] tx_rd_data;
  logic [10:0] tx_pkt_len;
  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  lbk_bulk_loopback dut_i (
    .clk(clk), .rst_n(rst_n), .rx_arm(rx_arm), .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
    .rx_commit(rx_commit), .rx_empty(rx_empty), .rx_full(rx_full), .tx_rd_en(tx_rd_en),
    .tx_release(tx_release), .tx_rd_data(tx_rd_data), .tx_pkt_len(tx_pkt_len),
    .tx_empty(tx_empty), .tx_full(tx_full), .busy(busy)
  );

  function automatic logic [7:0] pat(int id, int i);
    return 8'((id * 37) + (i * 3) + (i >> 8));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_arm();
    @(negedge clk) rx_arm = 1'b1;
    @(negedge clk) rx_arm = 1'b0;
  endtask

  // write len bytes of packet id, then commit; optional flag checks around the commit
  task automatic send_pkt(input int id, input int len, input bit flag_chk);
    int waited = 0;
    @(negedge clk);
    while (rx_full && waited < 2000) begin @(negedge clk); waited++; end
    if (waited >= 2000) chk("R10", "rx slot never armed", 1, 0);
    for (int i = 0; i < len; i++) begin
      rx_wr_en = 1'b1; rx_wr_data = pat(id, i);
      @(negedge clk);
    end
    rx_wr_en = 1'b0;
    if (flag_chk) chk("R3", "rx_empty after bytes, before commit", int'(rx_empty), 1);
    rx_commit = 1'b1;
    @(negedge clk) rx_commit = 1'b0;
    if (flag_chk) chk("R3", "rx_empty cycle after commit", int'(rx_empty), 0);
  endtask

  // read and release one transmit packet, comparing length and bytes
  task automatic recv_pkt(input int id, input int len, input string order_req);
    int waited = 0;
    int bad = 0;
    while (tx_empty && waited < 2000) begin @(negedge clk); waited++; end
    chk("R7", "tx packet arrival", int'(tx_empty), 0);
    chk("R5", "tx_pkt_len", int'(tx_pkt_len), len);
    for (int i = 0; i < len; i++) begin
      if (tx_rd_data != pat(id, i)) begin
        if (bad == 0)
          $display("FAIL %s byte %0d of packet %0d: actual=%0d expected=%0d",
                   order_req, i, id, tx_rd_data, pat(id, i));
        bad++;
      end
      tx_rd_en = 1'b1;
      @(negedge clk);
    end
    tx_rd_en = 1'b0;
    n_checks++;
    if (bad != 0) n_err++;
    tx_release = 1'b1;
    @(negedge clk) tx_release = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rx_empty", int'(rx_empty), 1);
    chk("R1", "rx_full", int'(rx_full), 1);
    chk("R1", "tx_empty", int'(tx_empty), 1);
    chk("R1", "tx_full", int'(tx_full), 0);
    chk("R1", "busy", int'(busy), 0);
  endtask

  task automatic t_unarmed_and_arm();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) rx_wr_en = 1'b1; rx_wr_data = 8'hA5;
    end
    @(negedge clk) rx_wr_en = 1'b0; rx_commit = 1'b1;
    @(negedge clk) rx_commit = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2", "rx_empty after unarmed commit", int'(rx_empty), 1);
    chk("R2", "tx_empty after unarmed commit", int'(tx_empty), 1);
    pulse_arm();
    chk("R2", "rx_full after one arm", int'(rx_full), 0);
    pulse_arm();
    chk("R2", "rx_full after two arms", int'(rx_full), 0);
  endtask

  // one packet alone: flags, copy duration, commit/release order, data
  task automatic t_single(input int id, input int len);
    int k = 0, nbusy = 0, tk = -1, rk = -1;
    send_pkt(id, len, 1'b1);
    do begin
      @(negedge clk);
      k++;
      if (busy) nbusy++;
      if (k == 1) chk("R3", "tx_empty in first copy cycle", int'(tx_empty), 1);
      if (!tx_empty && tk < 0) tk = k;
      if (rx_empty && rk < 0) rk = k;
    end while ((busy || k < 2) && k < 1000);
    chk("R8", $sformatf("busy cycles len=%0d", len), nbusy, len + 2);
    chk("R9", "rx release one cycle after tx commit", rk - tk, 1);
    recv_pkt(id, len, "R6");
    chk("R10", "rx_full after transfer", int'(rx_full), 0);
  endtask

  // transmit pool fills; copying stalls until the consumer frees a slot
  task automatic t_stall();
    int waited = 0;
    send_pkt(10, 3, 1'b0);
    send_pkt(11, 4, 1'b0);
    while (!tx_full && waited < 100) begin @(negedge clk); waited++; end
    chk("R4", "tx_full after two packets", int'(tx_full), 1);
    send_pkt(12, 5, 1'b0);
    repeat (20) @(negedge clk);
    chk("R4", "busy while tx full", int'(busy), 0);
    chk("R4", "rx packet held while tx full", int'(rx_empty), 0);
    chk("R10", "rx_full with one held packet", int'(rx_full), 0);
    send_pkt(13, 2, 1'b0);
    @(negedge clk);
    chk("R10", "rx_full with two held packets", int'(rx_full), 1);
    recv_pkt(10, 3, "R7");
    chk("R11", "tx_full after release", int'(tx_full), 0);
    recv_pkt(11, 4, "R7");
    recv_pkt(12, 5, "R7");
    recv_pkt(13, 2, "R7");
    repeat (5) @(negedge clk);
    chk("R10", "rx_full after all copied", int'(rx_full), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_unarmed_and_arm();
    t_single(1, 0);
    t_single(2, 1);
    t_single(3, 511);
    t_single(4, 512);
    t_stall();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule